// File: doc/BRIEF.md
# Byte Prefetch Queue with Flush

This block sits on the fetch side of a small processor and keeps instruction bytes ready ahead of the execution side. It fetches only in memory cycles that the rest of the machine leaves free. A one-bit grant input marks such a cycle. The block issues at most one single-byte read at a time and sends it to a plain memory port. Each returned byte goes into a six-entry FIFO. The consumer sees the oldest byte at the head outputs and removes it with a take strobe.

When a branch is taken, the consumer raises a redirect together with the target address. The queue is emptied at once and the fetch pointer moves to the target. A read that is still outstanding at that moment is allowed to finish, but its byte is thrown away. Every queue operation is reported one clock later as a two-bit code: nothing happened, the first byte of an instruction was taken, the queue was emptied, or a later byte of an instruction was taken.

Top module: `byte_prefetch_queue`

## Requirements
- R1: During and after a synchronous active-low reset the queue is empty (`head_valid` low), `queue_op` is 00 and the fetch address is `RESET_ADDR` (default 0).
- R2: `fetch_req` is high in a cycle only when `bus_grant` is high, `redirect` is low, no earlier fetch is still waiting for its response, and at least `MIN_FREE` (2) queue entries are free. A request is accepted in the cycle it is raised.
- R3: Successive requests carry addresses that rise by one each time. The sequence starts at `RESET_ADDR` after reset, or at the redirect target after a redirect.
- R4: Returned bytes are presented at `head_byte` in arrival order while `head_valid` is high. A take while `head_valid` is high removes the head byte.
- R5: A redirect empties the queue by the next cycle, and the next request uses `redirect_addr`.
- R6: A response to a fetch that was outstanding when a redirect occurred is discarded. This includes a response arriving in the same cycle as the redirect. No new request is issued until that response has returned.
- R7: `queue_op` reports, one cycle after the operation: 01 for a take with `take_first` high, 11 for a take with `take_first` low, 10 for a redirect, and 00 otherwise.
- R8: A redirect and a take in the same cycle are reported as 10, and no byte is consumed beyond the flush.
- R9: A take while the queue is empty is ignored: `queue_op` stays 00 and the queue contents are unchanged.
- R10: With `MIN_FREE` = 2 and depth 6, the queue never holds more than 5 bytes. With fetching granted continuously and nothing taken, it settles at exactly 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_grant | input | 1 | Memory cycle free for a fetch |
| fetch_req | output | 1 | Byte read request, accepted in the same cycle |
| fetch_addr | output | 16 | Address of the requested byte |
| fetch_rsp_valid | input | 1 | Read data returning for the outstanding request |
| fetch_rsp_data | input | 8 | Returned byte |
| redirect | input | 1 | Taken branch: flush and restart fetching |
| redirect_addr | input | 16 | Branch target address |
| take | input | 1 | Consumer removes the head byte |
| take_first | input | 1 | Taken byte is the first byte of an instruction |
| head_valid | output | 1 | Queue holds at least one byte |
| head_byte | output | 8 | Oldest byte in the queue |
| queue_op | output | 2 | Encoded queue operation of the previous cycle |

## Verification
On every cycle, the embedded assertions check several things:
- the spacing of requests and their address stepping;
- that a response never arrives without an outstanding fetch;
- that the queue occupancy stays under its limit;
- the status code that follows a redirect, a first-byte take or a take on an empty queue.

Some behaviours can only be shown by the bench scenarios, which compare every head byte with a reference queue:
- that a stale response is actually dropped;
- that bytes keep their order across wrap-around;
- that the queue settles at five entries when nothing is consumed;
- that redirect and take together consume nothing.

// File: rtl/pfq_pkg.sv
// Package: shared types of the byte prefetch queue.
// Assumes: the two-bit queue operation code is decoded by the consumer side.
package pfq_pkg;
    typedef enum logic [1:0] {
        QOP_NONE  = 2'b00,
        QOP_FIRST = 2'b01,
        QOP_FLUSH = 2'b10,
        QOP_NEXT  = 2'b11
    } qop_e;
endpackage

// File: rtl/pfq_fifo.sv
// Module: circular byte store for the prefetch queue.
// Assumes: the caller never pushes when full and never pops when empty;
// clear wins over push and pop in the same cycle.
module pfq_fifo #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [DATA_W-1:0] slot_view [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // One storage register per entry, written when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (push && !clr && wr_ptr == PTR_W'(i)) slot_q <= din;
        end
        assign slot_view[i] = slot_q;
    end

    assign dout = slot_view[rd_ptr];

    // Pointers and occupancy follow push, pop and clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Occupancy never wraps past the depth.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/pfq_fetch.sv
// Module: fetch pointer and single outstanding byte read.
// Assumes: memory answers each accepted request exactly once, in a later
// cycle; a redirect while a read is outstanding marks its answer stale.
module pfq_fetch #(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    input  logic              room_ok,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              rsp_valid,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              rsp_keep
);
    logic ptr_pending;
    logic ptr_stale;
    logic [ADDR_W-1:0] ptr_q;

    // Issue in a free memory cycle with room and nothing outstanding.
    assign req_valid = bus_grant && room_ok && !redirect && !ptr_pending;
    assign req_addr  = ptr_q;
    // Keep a response only if it belongs to the current fetch stream.
    assign rsp_keep  = rsp_valid && ptr_pending && !ptr_stale && !redirect;

    // Track the pointer, the outstanding read and its staleness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= RESET_ADDR;
            ptr_pending <= 1'b0;
            ptr_stale   <= 1'b0;
        end else if (redirect) begin
            ptr_q <= redirect_addr;
            if (ptr_pending && !rsp_valid) begin
                ptr_stale <= 1'b1;
            end else begin
                ptr_pending <= 1'b0;
                ptr_stale   <= 1'b0;
            end
        end else begin
            if (rsp_valid) begin
                ptr_pending <= 1'b0;
                ptr_stale   <= 1'b0;
            end
            if (req_valid) begin
                ptr_pending <= 1'b1;
                ptr_q       <= ptr_q + 1'b1;
            end
        end
    end

    // A request is always followed by a cycle without one (one read at a time).
    p_req_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    // Responses arrive only for an outstanding read.
    p_rsp_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ptr_pending);
    // Requests need a granted cycle.
    p_req_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (bus_grant && !redirect));
endmodule

// File: rtl/pfq_status.sv
// Module: encodes the queue operation of each cycle into a registered code.
// Assumes: take_ok is already qualified with a non-empty queue.
module pfq_status
    import pfq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic take_ok,
    input  logic first,
    output qop_e op_q
);
    // Flush outranks a take; an idle cycle reports no operation.
    always_ff @(posedge clk) begin
        if (!rst_n)       op_q <= QOP_NONE;
        else if (flush)   op_q <= QOP_FLUSH;
        else if (take_ok) op_q <= first ? QOP_FIRST : QOP_NEXT;
        else              op_q <= QOP_NONE;
    end
endmodule

// File: rtl/byte_prefetch_queue.sv
// Module: byte prefetch queue with branch flush (top).
// Fetches one byte at a time in granted memory cycles while at least
// MIN_FREE entries are free, hands bytes to the consumer, and flushes on
// redirect. Assumes a single outstanding read and in-order memory answers.
module byte_prefetch_queue
    import pfq_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter int                DEPTH      = 6,
    parameter int                MIN_FREE   = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_rsp_valid,
    input  logic [DATA_W-1:0] fetch_rsp_data,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              take,
    input  logic              take_first,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_byte,
    output logic [1:0]        queue_op
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] ROOM_LIMIT = CNT_W'(DEPTH - MIN_FREE);
    localparam logic [CNT_W-1:0] FILL_MAX   = CNT_W'(DEPTH - MIN_FREE + 1);

    logic [CNT_W-1:0] fill_count;
    logic             room_ok;
    logic             rsp_keep;
    logic             take_ok;
    qop_e             op_q;

    assign head_valid = (fill_count != '0);
    assign room_ok    = (fill_count <= ROOM_LIMIT);
    assign take_ok    = take && head_valid && !redirect;
    assign queue_op   = op_q;

    pfq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (redirect),
        .push  (rsp_keep),
        .din   (fetch_rsp_data),
        .pop   (take_ok),
        .dout  (head_byte),
        .count (fill_count)
    );

    pfq_fetch #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_grant     (bus_grant),
        .room_ok       (room_ok),
        .redirect      (redirect),
        .redirect_addr (redirect_addr),
        .rsp_valid     (fetch_rsp_valid),
        .req_valid     (fetch_req),
        .req_addr      (fetch_addr),
        .rsp_keep      (rsp_keep)
    );

    pfq_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (redirect),
        .take_ok (take_ok),
        .first   (take_first),
        .op_q    (op_q)
    );

    // Checker state: last issued address and whether a redirect came since.
    logic              chk_seen;
    logic              chk_redir;
    logic [ADDR_W-1:0] chk_last;
    logic [ADDR_W-1:0] chk_target;

    // Records each request and the most recent redirect target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen   <= 1'b0;
            chk_redir  <= 1'b0;
            chk_last   <= '0;
            chk_target <= '0;
        end else if (redirect) begin
            chk_redir  <= 1'b1;
            chk_target <= redirect_addr;
        end else if (fetch_req) begin
            chk_seen  <= 1'b1;
            chk_redir <= 1'b0;
            chk_last  <= fetch_addr;
        end
    end

    // Requests step by one, or start at the reset address or redirect target.
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (chk_redir ? fetch_addr == chk_target :
                       chk_seen  ? fetch_addr == chk_last + 1'b1 :
                                   fetch_addr == RESET_ADDR));
    // A redirect leaves the queue empty.
    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !head_valid);
    // A redirect is reported as 10, also with a take in the same cycle.
    p_flush_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (queue_op == 2'b10));
    // A first-byte take is reported as 01.
    p_first_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_first && head_valid && !redirect) |=> (queue_op == 2'b01));
    // A take on an empty queue is reported as no operation.
    p_empty_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !head_valid && !redirect) |=> (queue_op == 2'b00));
    // Occupancy stays at or under the fill limit.
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= FILL_MAX);
endmodule

// File: tb/byte_prefetch_queue_test.sv
module byte_prefetch_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_grant = 1'b0;
    logic        fetch_req;
    logic [15:0] fetch_addr;
    logic        fetch_rsp_valid = 1'b0;
    logic [7:0]  fetch_rsp_data = '0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_addr = '0;
    logic        take = 1'b0;
    logic        take_first = 1'b0;
    logic        head_valid;
    logic [7:0]  head_byte;
    logic [1:0]  queue_op;

    byte_prefetch_queue uut (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_data(fetch_rsp_data),
        .redirect(redirect), .redirect_addr(redirect_addr),
        .take(take), .take_first(take_first),
        .head_valid(head_valid), .head_byte(head_byte), .queue_op(queue_op)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;

    // Reference state.
    logic [7:0]  mq[$];
    logic [15:0] m_fetch = 16'h0000;
    logic        pend = 1'b0;
    logic [15:0] pend_addr = '0;
    int          pend_epoch = 0;
    int          epoch = 0;
    int          lat = 0;
    logic [1:0]  exp_op = 2'b00;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [1:0] op_code(input logic f, input logic popped, input logic fi);
        if (f) return 2'b10;
        if (popped) return fi ? 2'b01 : 2'b11;
        return 2'b00;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check request, update model, check outputs.
    task automatic step(input logic g, input logic f, input logic [15:0] fa,
                        input logic p, input logic fi);
        logic exp_req, delivered, keep, popped;
        logic [7:0] d;
        bus_grant = g; redirect = f; redirect_addr = fa; take = p; take_first = fi;
        delivered = pend && (lat == 0);
        d = memf(pend_addr);
        fetch_rsp_valid = delivered;
        fetch_rsp_data = delivered ? d : 8'h00;
        #1;
        exp_req = g && !f && !pend && (6 - mq.size() >= 2);
        chk(fetch_req == exp_req, "R2 request gating", 32'(fetch_req), 32'(exp_req));
        if (fetch_req && exp_req)
            chk(fetch_addr == m_fetch, "R3 R5 request address", 32'(fetch_addr), 32'(m_fetch));
        keep = delivered && (pend_epoch == epoch) && !f;
        popped = p && (mq.size() > 0) && !f;
        exp_op = op_code(f, popped, fi);
        if (f) begin
            mq.delete();
            m_fetch = fa;
            epoch++;
        end else begin
            if (popped) void'(mq.pop_front());
            if (keep) mq.push_back(d);
        end
        if (delivered) pend = 1'b0;
        else if (pend) lat--;
        if (fetch_req && exp_req) begin
            pend = 1'b1;
            pend_addr = fetch_addr;
            pend_epoch = epoch;
            lat = $urandom_range(3, 0);
            m_fetch = m_fetch + 16'd1;
        end
        @(posedge clk);
        @(negedge clk);
        fetch_rsp_valid = 1'b0;
        chk(queue_op == exp_op, "R7 queue_op code", 32'(queue_op), 32'(exp_op));
        chk(head_valid == (mq.size() != 0), "R4 R5 head_valid", 32'(head_valid), 32'(mq.size() != 0));
        if (head_valid && mq.size() != 0)
            chk(head_byte == mq[0], "R4 R6 head byte order", 32'(head_byte), 32'(mq[0]));
        chk(mq.size() <= 5, "R10 occupancy limit", 32'(mq.size()), 32'd5);
    endtask

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(head_valid == 1'b0, "R1 head_valid in reset", 32'(head_valid), 32'd0);
        chk(queue_op == 2'b00, "R1 queue_op in reset", 32'(queue_op), 32'd0);
        chk(fetch_addr == 16'h0000, "R1 fetch address in reset", 32'(fetch_addr), 32'd0);
        chk(fetch_req == 1'b0, "R1 no request in reset", 32'(fetch_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: continuous grant, nothing taken, settles at five bytes.
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (head_valid) n++;
            step(1'b0, 1'b0, 16'h0, 1'b1, (i == 0));
        end
        chk(n == 5, "R10 queue settles at five bytes", 32'(n), 32'd5);

        // R9: take on an empty queue.
        step(1'b0, 1'b0, 16'h0, 1'b1, 1'b1);
        chk(queue_op == 2'b00 && !head_valid, "R9 empty take ignored", 32'(queue_op), 32'd0);

        // R8: redirect and take in the same cycle.
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'h4000, 1'b1, 1'b1);
        chk(queue_op == 2'b10, "R8 redirect outranks take", 32'(queue_op), 32'd2);
        chk(head_valid == 1'b0, "R8 R5 queue emptied", 32'(head_valid), 32'd0);

        // R6: redirect while a fetch is outstanding.
        step(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 16'h8000, 1'b0, 1'b0);
        n = 0;
        while (!head_valid && n < 20) begin
            step(1'b1, 1'b0, 16'h0, 1'b0, 1'b0);
            n++;
        end
        chk(head_byte == memf(16'h8000), "R6 first byte after stale drop", 32'(head_byte), 32'(memf(16'h8000)));

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic g, f, p, fi;
            logic [15:0] fa;
            g  = ($urandom_range(9, 0) < 7);
            f  = ($urandom_range(39, 0) == 0);
            p  = ($urandom_range(1, 0) == 1);
            fi = ($urandom_range(2, 0) == 0);
            fa = 16'($urandom);
            step(g, f, fa, p, fi);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule